// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block is a single-cycle multiply-accumulate datapath for signal-processing kernels such as filters, correlators and adaptive weight updates. Each cycle in which the start strobe is high, it forms the product of two 17-bit two's-complement operands and either writes that product into a 40-bit accumulator, adds it to the accumulator or subtracts it from the accumulator. Each 17-bit operand is built from a 16-bit value, with its own control choosing sign extension or zero extension. The 8 guard bits above the 32-bit working range absorb intermediate growth during long sums.

A fractional mode doubles the product so that Q15 by Q15 gives a Q31 result. Optional rounding at bit 15 and optional clamping to the 32-bit range follow the add. A sticky overflow flag records any result that left the 32-bit range, and a zero flag reports an all-zero accumulator. Operand A can come from the port, from a temporary register loaded from the port, or from the upper half of the accumulator's 32-bit working range. The temporary register supports a held coefficient or feedback term.

Top module: `fmac_unit`

## Requirements
- R1: While reset is asserted (rst_n low), the accumulator is 0, the overflow flag is 0 and the zero flag is 1.
- R2: An operand whose sign control is 1 is sign-extended from 16 to 17 bits. An operand whose sign control is 0 is zero-extended. The product is the full two's-complement product of the two 17-bit values.
- R3: On a clock edge where `go` is high, `op` selects the update. 0 writes the product into the accumulator, 1 adds the product to it, 2 subtracts the product from it, and 3 leaves the accumulator and the overflow flag unchanged. When `go` is low, the accumulator does not change.
- R4: When `frac_en` is 1, the product is shifted left by one bit before it is added.
- R5: When `rnd_en` is 1, 0x8000 is added to the 40-bit result and bits 15:0 are then cleared. Rounding happens before the overflow test and before saturation.
- R6: When `sat_en` is 1 and the rounded result is above 0x7FFFFFFF or below -0x80000000 (signed), the accumulator is loaded with 0x007FFFFFFF or 0xFF80000000 respectively.
- R7: The overflow flag goes high after any update (op 0 to 2) whose rounded result lies outside the 32-bit signed range, whether or not `sat_en` is set. It stays high until a cycle with `ovf_clr` high. A new overflow in the same cycle as `ovf_clr` keeps the flag high.
- R8: The zero flag is high exactly when all 40 accumulator bits are 0.
- R9: `a_src` selects operand A. 0 and 3 select port `a_in`, 1 selects the temporary register, and 2 selects accumulator bits 31:16. When `t_load` is high, the temporary register takes `a_in` at the clock edge. An update in that same cycle still uses the old register value.
- R10: With `frac_en` and `sat_en` set, signed 0x8000 times signed 0x8000 with op 0 gives 0x007FFFFFFF and sets the overflow flag.
- R11: When `sat_en` is 0, the result is kept modulo 2^40 with no clamping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe for one update |
| op | input | 2 | Update kind: 0 replace, 1 add, 2 subtract, 3 none |
| a_in | input | 16 | Operand A value from the port |
| a_signed | input | 1 | Sign control for operand A |
| a_src | input | 2 | Operand A source select |
| b_in | input | 16 | Operand B value |
| b_signed | input | 1 | Sign control for operand B |
| t_load | input | 1 | Load a_in into the temporary register |
| frac_en | input | 1 | Fractional product doubling |
| rnd_en | input | 1 | Round at bit 15 |
| sat_en | input | 1 | Clamp to the 32-bit range |
| ovf_clr | input | 1 | Clear the sticky overflow flag |
| acc | output | 40 | Accumulator |
| ovf | output | 1 | Sticky overflow flag |
| zero | output | 1 | Accumulator is all zeros |

## Verification
The accumulator is fed back into every add and subtract. A wrong internal sum therefore shows at `acc` one cycle after the update that caused it and then stays, because later MAC updates carry the error forward until the next replace. The random stream mixes all operations and modes against a model of the accumulator, temporary register and flag. An error in the extension, shift, rounding or clamp logic shows at the next compare, one clock after the update. A corrupted temporary register or overflow flag shows when a later update reads that register or when the bench checks the flag against its clear history. Directed cases cover -1 by -1 in fractional mode, unsigned full-scale operands and flag clearing that coincides with a new overflow.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
   typedef enum logic [1:0] {
      OP_MPY = 2'd0,
      OP_MAC = 2'd1,
      OP_MAS = 2'd2,
      OP_NOP = 2'd3
   } fmac_op_e;

   typedef enum logic [1:0] {
      SRC_PORT = 2'd0,
      SRC_TREG = 2'd1,
      SRC_ACCH = 2'd2,
      SRC_ALT  = 2'd3
   } fmac_src_e;
endpackage

// File: rtl/fmac_opnd.sv
// Operand extension: 16-bit value to 17-bit two's complement
module fmac_opnd #(
   parameter int IN_W = 16
) (
   input  logic [IN_W-1:0]      raw,
   input  logic                 is_signed,
   output logic signed [IN_W:0] ext
);
   always_comb begin
      ext = $signed({is_signed & raw[IN_W-1], raw});
   end
endmodule

// File: rtl/fmac_mult.sv
// Signed multiplier with optional one-bit fractional doubling
module fmac_mult #(
   parameter int OPW    = 17,
   parameter int PROD_W = 2*OPW + 1
) (
   input  logic signed [OPW-1:0]    a,
   input  logic signed [OPW-1:0]    b,
   input  logic                     frac,
   output logic signed [PROD_W-1:0] prod
);
   localparam int RAW_W = 2*OPW;
   logic signed [RAW_W-1:0] raw;

   always_comb begin
      raw  = a * b;
      prod = frac ? {raw, 1'b0} : {raw[RAW_W-1], raw};
   end
endmodule

// File: rtl/fmac_post.sv
// Add/subtract, rounding and range limiting of the next accumulator value
module fmac_post
   import fmac_pkg::*;
#(
   parameter int ACC_W   = 40,
   parameter int PROD_W  = 35,
   parameter int SAT_W   = 32,
   parameter int RND_POS = 15,
   parameter bit HAS_RND = 1'b1,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic [ACC_W-1:0]         acc_q,
   input  logic signed [PROD_W-1:0] prod,
   input  logic [1:0]               op,
   input  logic                     rnd_en,
   input  logic                     sat_en,
   output logic [ACC_W-1:0]         acc_d,
   output logic                     range_hit
);
   localparam int GUARD = ACC_W - SAT_W + 1;
   localparam logic [ACC_W-1:0] RND_INC  = ACC_W'(1) << RND_POS;
   localparam logic [ACC_W-1:0] RND_MASK = ~((ACC_W'(1) << (RND_POS + 1)) - ACC_W'(1));
   localparam logic [ACC_W-1:0] LIM_HI   = {{GUARD{1'b0}}, {(SAT_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] LIM_LO   = {{GUARD{1'b1}}, {(SAT_W-1){1'b0}}};

   fmac_op_e         op_e;
   logic [ACC_W-1:0] prod_x;
   logic [ACC_W-1:0] base;
   logic [ACC_W-1:0] sum;
   logic [ACC_W-1:0] rounded;
   logic [GUARD-1:0] top_bits;

   always_comb begin
      op_e   = fmac_op_e'(op);
      prod_x = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
      base   = (op_e == OP_MPY) ? '0 : acc_q;
      sum    = (op_e == OP_MAS) ? (base - prod_x) : (base + prod_x);
   end

   generate
      if (HAS_RND) begin : g_rnd
         always_comb rounded = rnd_en ? ((sum + RND_INC) & RND_MASK) : sum;
      end else begin : g_nornd
         logic unused_rnd;
         always_comb begin
            unused_rnd = rnd_en;
            rounded    = sum;
         end
      end
   endgenerate

   always_comb begin
      top_bits  = rounded[ACC_W-1:SAT_W-1];
      range_hit = !((&top_bits) || !(|top_bits));
   end

   generate
      if (HAS_SAT) begin : g_sat
         always_comb begin
            if (sat_en && range_hit)
               acc_d = rounded[ACC_W-1] ? LIM_LO : LIM_HI;
            else
               acc_d = rounded;
         end
      end else begin : g_nosat
         logic unused_sat;
         always_comb begin
            unused_sat = sat_en;
            acc_d      = rounded;
         end
      end
   endgenerate
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
   import fmac_pkg::*;
#(
   parameter int IN_W    = 16,
   parameter int ACC_W   = 40,
   parameter int SAT_W   = 32,
   parameter int RND_POS = 15,
   parameter bit HAS_RND = 1'b1,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [1:0]       op,
   input  logic [IN_W-1:0]  a_in,
   input  logic             a_signed,
   input  logic [1:0]       a_src,
   input  logic [IN_W-1:0]  b_in,
   input  logic             b_signed,
   input  logic             t_load,
   input  logic             frac_en,
   input  logic             rnd_en,
   input  logic             sat_en,
   input  logic             ovf_clr,
   output logic [ACC_W-1:0] acc,
   output logic             ovf,
   output logic             zero
);
   localparam int OPW    = IN_W + 1;
   localparam int PROD_W = 2*OPW + 1;

   generate
      if (ACC_W <= PROD_W) begin : g_chk_acc
         $error("fmac_unit: ACC_W must exceed the doubled product width");
      end
      if (SAT_W < IN_W || SAT_W >= ACC_W) begin : g_chk_sat
         $error("fmac_unit: SAT_W must lie in [IN_W, ACC_W)");
      end
      if (RND_POS + 1 >= SAT_W) begin : g_chk_rnd
         $error("fmac_unit: RND_POS must sit below the saturation range");
      end
   endgenerate

   logic [IN_W-1:0]         treg_q;
   logic [ACC_W-1:0]        acc_q;
   logic                    ovf_q;
   logic [IN_W-1:0]         a_raw;
   logic signed [OPW-1:0]   a_x;
   logic signed [OPW-1:0]   b_x;
   logic signed [PROD_W-1:0] prod;
   logic [ACC_W-1:0]        acc_d;
   logic                    range_hit;
   logic                    upd;

   always_comb begin
      unique case (fmac_src_e'(a_src))
         SRC_TREG: a_raw = treg_q;
         SRC_ACCH: a_raw = acc_q[SAT_W-1:SAT_W-IN_W];
         default:  a_raw = a_in;
      endcase
      upd = go && (fmac_op_e'(op) != OP_NOP);
   end

   fmac_opnd #(.IN_W(IN_W)) u_ext_a (.raw(a_raw), .is_signed(a_signed), .ext(a_x));
   fmac_opnd #(.IN_W(IN_W)) u_ext_b (.raw(b_in),  .is_signed(b_signed), .ext(b_x));

   fmac_mult #(.OPW(OPW), .PROD_W(PROD_W)) u_mult (
      .a(a_x), .b(b_x), .frac(frac_en), .prod(prod)
   );

   fmac_post #(
      .ACC_W(ACC_W), .PROD_W(PROD_W), .SAT_W(SAT_W), .RND_POS(RND_POS),
      .HAS_RND(HAS_RND), .HAS_SAT(HAS_SAT)
   ) u_post (
      .acc_q(acc_q), .prod(prod), .op(op), .rnd_en(rnd_en), .sat_en(sat_en),
      .acc_d(acc_d), .range_hit(range_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         treg_q <= '0;
         acc_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (t_load) treg_q <= a_in;
         if (upd)    acc_q  <= acc_d;
         if (upd && range_hit) ovf_q <= 1'b1;
         else if (ovf_clr)     ovf_q <= 1'b0;
      end
   end

   always_comb begin
      acc  = acc_q;
      ovf  = ovf_q;
      zero = (acc_q == '0);
   end
endmodule

// File: rtl/fmac_chk.sv
module fmac_chk #(
   parameter int IN_W    = 16,
   parameter int ACC_W   = 40,
   parameter int SAT_W   = 32,
   parameter int RND_POS = 15
) (
   input logic             clk,
   input logic             rst_n,
   input logic             go,
   input logic [1:0]       op,
   input logic [IN_W-1:0]  a_in,
   input logic [1:0]       a_src,
   input logic             frac_en,
   input logic             rnd_en,
   input logic             sat_en,
   input logic             ovf_clr,
   input logic [ACC_W-1:0] acc,
   input logic             ovf,
   input logic             zero
);
   localparam logic signed [ACC_W-1:0] HI = (ACC_W'(1) << (SAT_W-1)) - ACC_W'(1);
   localparam logic signed [ACC_W-1:0] LO = -(ACC_W'(1) << (SAT_W-1));

   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !ovf_clr) |=> ovf);

   a_r6_sat_range: assert property (@(posedge clk) disable iff (!rst_n)
      (go && sat_en && op != 2'd3) |=> ($signed(acc) <= HI && $signed(acc) >= LO));

   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!go || op == 2'd3) |=> $stable(acc));

   a_r3_nop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == 2'd3 && !ovf_clr) |=> $stable(ovf));

   a_r5_round_low: assert property (@(posedge clk) disable iff (!rst_n)
      (go && rnd_en && !sat_en && op != 2'd3) |=> (acc[RND_POS:0] == '0));

   a_r2_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == 2'd0 && a_src == 2'd0 && a_in == '0 && !rnd_en) |=> zero);

   a_r8_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      zero |-> !(|acc));

   a_r4_frac_even: assert property (@(posedge clk) disable iff (!rst_n)
      (go && op == 2'd0 && frac_en && !sat_en) |=> !acc[0]);
endmodule

bind fmac_unit fmac_chk #(
   .IN_W(IN_W), .ACC_W(ACC_W), .SAT_W(SAT_W), .RND_POS(RND_POS)
) u_fmac_chk (
   .clk(clk), .rst_n(rst_n), .go(go), .op(op), .a_in(a_in), .a_src(a_src),
   .frac_en(frac_en), .rnd_en(rnd_en), .sat_en(sat_en), .ovf_clr(ovf_clr),
   .acc(acc), .ovf(ovf), .zero(zero)
);

// File: tb/tb_fmac_unit.sv
`timescale 1ns/1ps
module tb_fmac_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        go = 1'b0;
   logic [1:0]  op = '0;
   logic [15:0] a_in = '0;
   logic        a_signed = 1'b0;
   logic [1:0]  a_src = '0;
   logic [15:0] b_in = '0;
   logic        b_signed = 1'b0;
   logic        t_load = 1'b0;
   logic        frac_en = 1'b0;
   logic        rnd_en = 1'b0;
   logic        sat_en = 1'b0;
   logic        ovf_clr = 1'b0;
   logic [39:0] acc;
   logic        ovf;
   logic        zero;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [39:0] m_acc = '0;
   logic [15:0] m_treg = '0;
   logic        m_ovf = 1'b0;

   always #2 clk = ~clk;

   fmac_unit dut (
      .clk(clk), .rst_n(rst_n), .go(go), .op(op), .a_in(a_in), .a_signed(a_signed),
      .a_src(a_src), .b_in(b_in), .b_signed(b_signed), .t_load(t_load),
      .frac_en(frac_en), .rnd_en(rnd_en), .sat_en(sat_en), .ovf_clr(ovf_clr),
      .acc(acc), .ovf(ovf), .zero(zero)
   );

   task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%010h expected 0x%010h", tag, act, exp);
      end
   endtask

   function automatic longint xt(input logic [15:0] v, input bit s);
      return s ? longint'($signed(v)) : longint'({48'd0, v});
   endfunction

   task automatic vec(input bit g, input logic [1:0] o, input logic [1:0] s,
                      input logic [15:0] a, input bit as, input logic [15:0] b, input bit bs,
                      input bit tl, input bit fr, input bit rn, input bit st, input bit oc,
                      input string tag);
      logic [15:0] araw;
      longint p, base, r, v;
      logic [39:0] w;
      bit hit, upd;
      string t;
      go = g; op = o; a_src = s; a_in = a; a_signed = as; b_in = b; b_signed = bs;
      t_load = tl; frac_en = fr; rnd_en = rn; sat_en = st; ovf_clr = oc;
      araw = (s == 2'd1) ? m_treg : (s == 2'd2) ? m_acc[31:16] : a;
      p = xt(araw, as) * xt(b, bs);
      if (fr) p = p * 2;
      base = (o == 2'd0) ? 64'sd0 : longint'($signed(m_acc));
      r = (o == 2'd2) ? base - p : base + p;
      if (rn) r = (r + 32768) & ~longint'(65535);
      w = r[39:0];
      v = longint'($signed(w));
      hit = (v > 64'sd2147483647) || (v < -64'sd2147483648);
      if (st && hit) w = (v > 0) ? 40'h007FFFFFFF : 40'hFF80000000;
      upd = g && (o != 2'd3);
      if (upd) m_acc = w;
      if (upd && hit) m_ovf = 1'b1;
      else if (oc) m_ovf = 1'b0;
      if (tl) m_treg = a;
      if (tag != "") t = tag;
      else if (!upd) t = "R3";
      else if (st && hit) t = "R6";
      else if (rn) t = "R5";
      else if (fr) t = "R4";
      else if (s == 2'd1 || s == 2'd2) t = "R9";
      else if (!st && hit) t = "R11";
      else t = "R2";
      @(negedge clk);
      check(t, acc, m_acc);
      check("R7 ovf", {39'd0, ovf}, {39'd0, m_ovf});
      check("R8 zero", {39'd0, zero}, {39'd0, (m_acc == 40'd0)});
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      check("R1 acc", acc, 40'd0);
      check("R1 ovf", {39'd0, ovf}, 40'd0);
      check("R1 zero", {39'd0, zero}, 40'd1);
      rst_n = 1'b1;

      // R10: -1 x -1 fractional, saturated
      vec(1, 0, 0, 16'h8000, 1, 16'h8000, 1, 0, 1, 0, 1, 0, "R10");
      check("R10 exact", acc, 40'h007FFFFFFF);
      // R7: clear coinciding with new overflow keeps flag
      vec(1, 0, 0, 16'h8000, 1, 16'h8000, 1, 0, 1, 0, 1, 1, "R7");
      vec(0, 0, 0, 16'h0000, 0, 16'h0000, 0, 0, 0, 0, 0, 1, "R7");
      // R2: unsigned full scale vs signed
      vec(1, 0, 0, 16'hFFFF, 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R2");
      check("R2 exact", acc, 40'h00FFFE0001);
      vec(1, 0, 0, 16'hFFFF, 1, 16'hFFFF, 0, 0, 0, 0, 0, 0, "R2");
      // R3: MAC / MAS / NOP
      vec(1, 1, 0, 16'h0003, 1, 16'h0004, 1, 0, 0, 0, 0, 0, "R3");
      vec(1, 2, 0, 16'h0010, 1, 16'h0010, 1, 0, 0, 0, 0, 0, "R3");
      vec(1, 3, 0, 16'h7FFF, 1, 16'h7FFF, 1, 0, 0, 0, 0, 0, "R3");
      // R5: rounding of a small positive and negative value
      vec(1, 0, 0, 16'h0100, 1, 16'h0080, 1, 0, 0, 1, 0, 0, "R5");
      vec(1, 2, 0, 16'h0100, 1, 16'h0081, 1, 0, 0, 1, 0, 0, "R5");
      // R9: temp register load then use, accumulator high word
      vec(1, 0, 0, 16'h1234, 1, 16'h0001, 1, 1, 0, 0, 0, 0, "R9");
      vec(1, 0, 1, 16'h0000, 1, 16'h0002, 1, 0, 0, 0, 0, 0, "R9");
      vec(1, 0, 2, 16'h0000, 1, 16'h0003, 1, 0, 0, 0, 0, 0, "R9");
      // R6 negative clamp and R11 wrap without clamp
      vec(1, 0, 0, 16'h7FFF, 1, 16'h8000, 1, 0, 1, 0, 0, 0, "");
      repeat (4) vec(1, 1, 0, 16'h7FFF, 1, 16'h8000, 1, 0, 1, 0, 1, 0, "R6");
      repeat (300) vec(1, 1, 0, 16'h7FFF, 1, 16'h7FFF, 1, 0, 1, 0, 0, 0, "R11");

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] rv;
         rv = $urandom();
         vec((rv[3:0] != 0), rv[5:4], rv[7:6], 16'($urandom()), rv[8],
             16'($urandom()), rv[9], rv[10], rv[11], rv[12], rv[13],
             (rv[17:14] == 0), "");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule